// File: doc/BRIEF.md
# Serial Port Host Register and Command Controller

This block is the register front end of a serial port. A host reaches it over a simple byte bus with a 6-bit address, separate read and write strobes and combinational read data. It keeps a small bank of mode registers behind a pointer that moves forward on each write. It also keeps an interrupt mask, a delta-break flag, the transmitter and receiver enables and a single transmit holding byte. Status and interrupt status are assembled from that state and from the fill level of an external receive queue.

Command writes carry three fields. The block decodes them in a fixed order: the miscellaneous action first, then the transmitter action, then the receiver action. The held transmit byte goes to a downstream serialiser over a valid/ready handshake. A read of the data offset pops the receive queue. One level-sensitive interrupt line is high whenever an unmasked interrupt-status bit is set. The baud divisor registers are read-only constants set by parameters. The auxiliary port offset always reads zero.

Top module: `uart_hostif`

## Requirements
- R1: Offsets are 0x00 mode, 0x04 status (read), 0x08 command (write), 0x0C receive data (read) or transmit data (write), 0x14 interrupt status (read) or interrupt mask (write), 0x18 and 0x1C divisor constants (read). Reads of 0x08, 0x10 and any other unlisted offset return 0. Writes to 0x04, 0x10, 0x18, 0x1C and unlisted offsets change no state.
- R2: A write to 0x00 stores into the mode register the pointer selects, then moves the pointer to the second register. A read of 0x00 returns the selected register. Command misc code 1 returns the pointer to the first register.
- R3: Status bits are: bit0 receive queue non-empty, bit1 queue level equal to RXQ_DEPTH, bit2 transmitter enabled, bit3 transmit holding byte empty. Bits 7:4 read 0.
- R4: Command bits 6:4 are misc (1 pointer reset, 2 receiver reset, 3 transmitter reset, 5 clear delta-break, others no effect). Bits 3:2 control the transmitter and bits 1:0 the receiver (1 enable, 2 disable, 3 ignored). All three fields apply in one write, in the order misc, transmitter, receiver.
- R5: A write to 0x0C loads the holding byte and clears transmit-empty. tx_valid is high while the transmitter is enabled and the byte is held. Transmit-empty sets again in the cycle after tx_valid and tx_ready are both high.
- R6: A transmitter reset disables the transmitter, sets transmit-empty, drops any held byte and clears status bit2.
- R7: Interrupt status bit0 equals transmitter enabled. Bit1 equals queue full when mode register 0 bit6 is 1, and queue non-empty when it is 0. Bit2 is the delta-break flag. Bits 7:3 are 0.
- R8: irq is high exactly when interrupt status AND interrupt mask is nonzero. A mask of zero holds irq low.
- R9: Reset clears the mode registers, the pointer, the mask, delta-break and both enables. Status then reads 0x08 and tx_valid and irq are low.
- R10: A read of 0x0C with a non-empty queue returns rxq_data and pulses rxq_pop for that cycle. With an empty queue it returns 0 and does not pop.
- R11: Receiver commands set or clear rx_en. A receiver reset clears rx_en and pulses rxq_flush during the command write.
- R12: A pulse on rx_break_evt sets delta-break. Misc code 5 clears it. If both happen in the same cycle, the set wins.
- R13: Offsets 0x18 and 0x1C read the DIV_UPPER and DIV_LOWER parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of 0x0C pops) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| tx_data | output | 8 | Held transmit byte |
| tx_valid | output | 1 | Byte offered to the serialiser |
| tx_ready | input | 1 | Serialiser accepts the byte |
| rxq_data | input | 8 | Head byte of the receive queue |
| rxq_level | input | LVL_W | Receive queue fill level |
| rxq_pop | output | 1 | Pop the queue head |
| rxq_flush | output | 1 | Empty the queue |
| rx_en | output | 1 | Receiver enabled |
| rx_break_evt | input | 1 | Break detected on the line |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is a pending transmit byte while the transmitter is disabled. The byte must survive the disable and be dropped only by a transmitter reset. The stimulus holds tx_ready low, loads a byte, disables and then resets in one command. The other hard case is a single command that combines a reset with an enable. Here the field order decides the final state, and the bench checks that the flush pulse and the surviving enable appear together. Selection of the receive interrupt source is exercised by stepping the queue level between 1 and full under both settings of the mode bit.

// File: rtl/uart_hostif_pkg.sv
package uart_hostif_pkg;

    localparam int ADDR_W     = 6;
    localparam int BYTE_W     = 8;
    localparam int RXSEL_BIT  = 6;

    typedef enum logic [ADDR_W-1:0] {
        OFS_MODE = 6'h00,
        OFS_STAT = 6'h04,
        OFS_CMD  = 6'h08,
        OFS_DATA = 6'h0C,
        OFS_AUX  = 6'h10,
        OFS_INT  = 6'h14,
        OFS_DIVH = 6'h18,
        OFS_DIVL = 6'h1C
    } reg_ofs_e;

    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_e;

    typedef enum logic [1:0] {
        DIR_NOP  = 2'd0,
        DIR_ON   = 2'd1,
        DIR_OFF  = 2'd2,
        DIR_RSVD = 2'd3
    } dir_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

    typedef struct packed {
        logic rx_brk;
        logic frame_err;
        logic par_err;
        logic ovr_err;
        logic tx_empty;
        logic tx_rdy;
        logic q_full;
        logic q_ready;
    } stat_t;

    typedef struct packed {
        logic [4:0] zero;
        logic       brk;
        logic       rx;
        logic       tx;
    } isr_t;

    function automatic cmd_act_t decode_cmd(input logic [6:0] b);
        cmd_act_t a;
        misc_e    m;
        dir_e     t;
        dir_e     r;
        m = misc_e'(b[6:4]);
        t = dir_e'(b[3:2]);
        r = dir_e'(b[1:0]);
        a         = '0;
        a.ptr_rst = (m == MISC_PTR_RST);
        a.rx_rst  = (m == MISC_RX_RST);
        a.tx_rst  = (m == MISC_TX_RST);
        a.brk_clr = (m == MISC_BRK_CLR);
        a.tx_on   = (t == DIR_ON);
        a.tx_off  = (t == DIR_OFF);
        a.rx_on   = (r == DIR_ON);
        a.rx_off  = (r == DIR_OFF);
        return a;
    endfunction

endpackage

// File: rtl/uhi_cmd_decode.sv
module uhi_cmd_decode
    import uart_hostif_pkg::*;
(
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_act_t          act
);
    logic unused_cmd_msb;
    assign unused_cmd_msb = cmd_byte[7];

    always_comb begin
        act = '0;
        if (cmd_we) begin
            act = decode_cmd(cmd_byte[6:0]);
        end
    end
endmodule

// File: rtl/uhi_mode_regs.sv
module uhi_mode_regs
    import uart_hostif_pkg::*;
#(
    parameter int NUM_MODE = 2,
    localparam int PTR_W = (NUM_MODE > 1) ? $clog2(NUM_MODE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ptr_rst,
    output logic [PTR_W-1:0]  ptr,
    output logic [BYTE_W-1:0] sel_data,
    output logic [BYTE_W-1:0] first_mode
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_MODE - 1);

    logic [BYTE_W-1:0] regs_q [NUM_MODE];

    for (genvar g = 0; g < NUM_MODE; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (mode_we && (ptr == PTR_W'(g))) begin
                regs_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ptr_rst) begin
            ptr <= '0;
        end else if (mode_we && (ptr != LAST)) begin
            ptr <= ptr + 1'b1;
        end
    end

    assign sel_data   = regs_q[ptr];
    assign first_mode = regs_q[0];
endmodule

// File: rtl/uhi_tx_holder.sv
module uhi_tx_holder
    import uart_hostif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tx_rst,
    input  logic              tx_on,
    input  logic              tx_off,
    input  logic              tx_ready,
    output logic              tx_en,
    output logic              tx_empty,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);
    logic accept;
    assign tx_valid = tx_en && !tx_empty;
    assign accept   = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en <= 1'b0;
        end else if (tx_on) begin
            tx_en <= 1'b1;
        end else if (tx_off || tx_rst) begin
            tx_en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_empty <= 1'b1;
            tx_data  <= '0;
        end else if (data_we) begin
            tx_empty <= 1'b0;
            tx_data  <= wdata;
        end else if (tx_rst || accept) begin
            tx_empty <= 1'b1;
        end
    end
endmodule

// File: rtl/uhi_irq_ctrl.sv
module uhi_irq_ctrl
    import uart_hostif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              brk_evt,
    input  logic              brk_clr,
    input  logic              tx_rdy,
    input  logic              q_ready,
    input  logic              q_full,
    input  logic              rx_sel_full,
    output isr_t              isr,
    output logic [BYTE_W-1:0] imr,
    output logic              irq
);
    logic brk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q <= 1'b0;
        end else if (brk_evt) begin
            brk_q <= 1'b1;
        end else if (brk_clr) begin
            brk_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imr <= '0;
        end else if (mask_we) begin
            imr <= wdata;
        end
    end

    always_comb begin
        isr      = '0;
        isr.tx   = tx_rdy;
        isr.rx   = rx_sel_full ? q_full : q_ready;
        isr.brk  = brk_q;
    end

    assign irq = |(isr & imr);
endmodule

// File: rtl/uart_hostif.sv
module uart_hostif
    import uart_hostif_pkg::*;
#(
    parameter int RXQ_DEPTH = 4,
    parameter int NUM_MODE = 2,
    parameter logic [7:0] DIV_UPPER = 8'h00,
    parameter logic [7:0] DIV_LOWER = 8'h00,
    localparam int LVL_W = $clog2(RXQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    input  logic [7:0]       rxq_data,
    input  logic [LVL_W-1:0] rxq_level,
    output logic             rxq_pop,
    output logic             rxq_flush,
    output logic             rx_en,
    input  logic             rx_break_evt,
    output logic             irq
);
    localparam int PTR_W = (NUM_MODE > 1) ? $clog2(NUM_MODE) : 1;

    logic              we_mode, we_cmd, we_data, we_mask, rd_data;
    cmd_act_t          act;
    logic [PTR_W-1:0]  mode_ptr;
    logic [BYTE_W-1:0] mode_sel, mode_first;
    logic              tx_en, tx_empty;
    logic              q_ready, q_full;
    isr_t              isr;
    logic [BYTE_W-1:0] imr_q;
    stat_t             stat;

    assign we_mode = bus_wr && (bus_addr == OFS_MODE);
    assign we_cmd  = bus_wr && (bus_addr == OFS_CMD);
    assign we_data = bus_wr && (bus_addr == OFS_DATA);
    assign we_mask = bus_wr && (bus_addr == OFS_INT);
    assign rd_data = bus_rd && (bus_addr == OFS_DATA);

    assign q_ready = (rxq_level != '0);
    assign q_full  = (rxq_level >= LVL_W'(RXQ_DEPTH));

    uhi_cmd_decode u_dec (
        .cmd_we   (we_cmd),
        .cmd_byte (bus_wdata),
        .act      (act)
    );

    uhi_mode_regs #(.NUM_MODE(NUM_MODE)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_we    (we_mode),
        .wdata      (bus_wdata),
        .ptr_rst    (act.ptr_rst),
        .ptr        (mode_ptr),
        .sel_data   (mode_sel),
        .first_mode (mode_first)
    );

    uhi_tx_holder u_tx (
        .clk      (clk),
        .rst      (rst),
        .data_we  (we_data),
        .wdata    (bus_wdata),
        .tx_rst   (act.tx_rst),
        .tx_on    (act.tx_on),
        .tx_off   (act.tx_off),
        .tx_ready (tx_ready),
        .tx_en    (tx_en),
        .tx_empty (tx_empty),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    uhi_irq_ctrl u_irq (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (we_mask),
        .wdata       (bus_wdata),
        .brk_evt     (rx_break_evt),
        .brk_clr     (act.brk_clr),
        .tx_rdy      (tx_en),
        .q_ready     (q_ready),
        .q_full      (q_full),
        .rx_sel_full (mode_first[RXSEL_BIT]),
        .isr         (isr),
        .imr         (imr_q),
        .irq         (irq)
    );

    // Receiver enable: misc reset applies first, then the receiver field.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
        end else if (act.rx_on) begin
            rx_en <= 1'b1;
        end else if (act.rx_off || act.rx_rst) begin
            rx_en <= 1'b0;
        end
    end

    assign rxq_flush = act.rx_rst;
    assign rxq_pop   = rd_data && q_ready;

    always_comb begin
        stat          = '0;
        stat.q_ready  = q_ready;
        stat.q_full   = q_full;
        stat.tx_rdy   = tx_en;
        stat.tx_empty = tx_empty;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_MODE: bus_rdata = mode_sel;
                OFS_STAT: bus_rdata = stat;
                OFS_DATA: bus_rdata = q_ready ? rxq_data : 8'h00;
                OFS_INT:  bus_rdata = isr;
                OFS_DIVH: bus_rdata = DIV_UPPER;
                OFS_DIVL: bus_rdata = DIV_LOWER;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_hostif_chk.sv
module uart_hostif_chk #(
    parameter int LVL_W = 3,
    parameter int PTR_W = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [5:0]       bus_addr,
    input logic             bus_wr,
    input logic [7:0]       bus_wdata,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             irq,
    input logic             rx_en,
    input logic             rxq_pop,
    input logic [LVL_W-1:0] rxq_level,
    input logic [PTR_W-1:0] mode_ptr,
    input logic [7:0]       imr
);
    p_ptr_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h00) |=> (mode_ptr != '0));

    p_tx_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !(bus_wr && bus_addr == 6'h0C)) |=> !tx_valid);

    p_tx_reset_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h08 && bus_wdata[6:4] == 3'd3 && bus_wdata[3:2] != 2'd1)
        |=> !tx_valid);

    p_mask_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (imr == 8'h00) |-> !irq);

    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (!tx_valid && !irq && !rx_en && mode_ptr == '0));

    p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
        rxq_pop |-> (rxq_level != '0));

    p_rx_enable_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h08 && bus_wdata[1:0] == 2'd1) |=> rx_en);
endmodule

bind uart_hostif uart_hostif_chk #(.LVL_W(LVL_W), .PTR_W(PTR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .irq       (irq),
    .rx_en     (rx_en),
    .rxq_pop   (rxq_pop),
    .rxq_level (rxq_level),
    .mode_ptr  (mode_ptr),
    .imr       (imr_q)
);

// File: tb/uart_hostif_tb_top.sv
module uart_hostif_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] DIVH = 8'h5C;
    localparam logic [7:0] DIVL = 8'hA3;
    localparam int NVEC = 30;

    // {write, addr, wdata, expected read data}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 6'h04, 8'h00, 8'h08},   // R9 status after reset
        {1'b0, 6'h14, 8'h00, 8'h00},   // R9 isr after reset
        {1'b0, 6'h00, 8'h00, 8'h00},   // R9 mode after reset
        {1'b1, 6'h00, 8'h40, 8'h00},   // R2 first mode
        {1'b1, 6'h00, 8'h13, 8'h00},   // R2 second mode
        {1'b0, 6'h00, 8'h00, 8'h13},   // R2 pointer advanced
        {1'b1, 6'h00, 8'h17, 8'h00},   // R2 stays on second
        {1'b0, 6'h00, 8'h00, 8'h17},   // R2
        {1'b1, 6'h08, 8'h10, 8'h00},   // R2 pointer reset
        {1'b0, 6'h00, 8'h00, 8'h40},   // R2 first again
        {1'b1, 6'h08, 8'h04, 8'h00},   // R4 tx enable
        {1'b0, 6'h04, 8'h00, 8'h0C},   // R3
        {1'b0, 6'h14, 8'h00, 8'h01},   // R7 tx source
        {1'b1, 6'h0C, 8'hA5, 8'h00},   // R5 load, ready low
        {1'b0, 6'h04, 8'h00, 8'h04},   // R5 empty cleared
        {1'b1, 6'h08, 8'h08, 8'h00},   // R4 tx disable
        {1'b0, 6'h04, 8'h00, 8'h00},   // R3 pending, disabled
        {1'b0, 6'h14, 8'h00, 8'h00},   // R7
        {1'b1, 6'h08, 8'h34, 8'h00},   // R4 reset tx then enable
        {1'b0, 6'h04, 8'h00, 8'h0C},   // R4 R6 byte dropped, enabled
        {1'b1, 6'h08, 8'h0C, 8'h00},   // R4 reserved tx code
        {1'b0, 6'h04, 8'h00, 8'h0C},   // R4 unchanged
        {1'b0, 6'h08, 8'h00, 8'h00},   // R1 command reads 0
        {1'b0, 6'h10, 8'h00, 8'h00},   // R1 aux reads 0
        {1'b0, 6'h18, 8'h00, DIVH},    // R13
        {1'b1, 6'h1C, 8'hFF, 8'h00},   // R1 write ignored
        {1'b0, 6'h1C, 8'h00, DIVL},    // R13 R1
        {1'b1, 6'h04, 8'hFF, 8'h00},   // R1 write ignored
        {1'b1, 6'h3C, 8'h77, 8'h00},   // R1 unmapped write
        {1'b0, 6'h3C, 8'h00, 8'h00}    // R1 unmapped read
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] rxq_data = '0;
    logic [2:0] rxq_level = '0;
    logic       rxq_pop;
    logic       rxq_flush;
    logic       rx_en;
    logic       rx_break_evt = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_hostif #(.RXQ_DEPTH(4), .NUM_MODE(2), .DIV_UPPER(DIVH), .DIV_LOWER(DIVL)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rxq_data     (rxq_data),
        .rxq_level    (rxq_level),
        .rxq_pop      (rxq_pop),
        .rxq_flush    (rxq_flush),
        .rx_en        (rx_en),
        .rx_break_evt (rx_break_evt),
        .irq          (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d, output logic fl);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 fl = rxq_flush;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d, output logic p);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata; p = rxq_pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       pp, fl;
        do_reset();
        check("R9 tx_valid", {7'd0, tx_valid}, 8'h00);
        check("R9 irq", {7'd0, irq}, 8'h00);
        check("R9 rx_en", {7'd0, rx_en}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][22]) begin
                bus_write(VEC[i][21:16], VEC[i][15:8], fl);
            end else begin
                bus_read(VEC[i][21:16], rd, pp);
                check($sformatf("R1-table vec %0d", i), rd, VEC[i][7:0]);
            end
        end

        // R5 handshake
        bus_write(6'h0C, 8'h5A, fl);
        check("R5 valid", {7'd0, tx_valid}, 8'h01);
        check("R5 data", tx_data, 8'h5A);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check("R5 accepted", {7'd0, tx_valid}, 8'h00);
        bus_read(6'h04, rd, pp);
        check("R5 empty again", rd, 8'h0C);

        // R7 R8 interrupt sources (mode0 = 0x40 selects full)
        bus_write(6'h14, 8'h01, fl);
        check("R8 tx irq", {7'd0, irq}, 8'h01);
        bus_write(6'h14, 8'h02, fl);
        check("R8 masked", {7'd0, irq}, 8'h00);
        rxq_level = 3'd1;
        bus_read(6'h14, rd, pp);
        check("R7 full-select level1", rd, 8'h01);
        check("R8 no rx irq", {7'd0, irq}, 8'h00);
        rxq_level = 3'd4;
        bus_read(6'h14, rd, pp);
        check("R7 full-select full", rd, 8'h03);
        check("R8 rx irq", {7'd0, irq}, 8'h01);
        bus_read(6'h04, rd, pp);
        check("R3 full status", rd, 8'h0F);
        rxq_level = 3'd0;
        bus_write(6'h08, 8'h10, fl);
        bus_write(6'h00, 8'h00, fl);
        rxq_level = 3'd1;
        bus_read(6'h14, rd, pp);
        check("R7 ready-select", rd, 8'h03);
        check("R8 ready irq", {7'd0, irq}, 8'h01);

        // R10 pops
        rxq_level = 3'd2; rxq_data = 8'h3C;
        bus_read(6'h0C, rd, pp);
        check("R10 data", rd, 8'h3C);
        check("R10 pop", {7'd0, pp}, 8'h01);
        rxq_level = 3'd0;
        bus_read(6'h0C, rd, pp);
        check("R10 empty data", rd, 8'h00);
        check("R10 no pop", {7'd0, pp}, 8'h00);

        // R11 R4 receiver
        bus_write(6'h08, 8'h01, fl);
        check("R11 enable", {7'd0, rx_en}, 8'h01);
        bus_write(6'h08, 8'h03, fl);
        check("R4 reserved rx", {7'd0, rx_en}, 8'h01);
        bus_write(6'h08, 8'h02, fl);
        check("R11 disable", {7'd0, rx_en}, 8'h00);
        bus_write(6'h08, 8'h21, fl);
        check("R11 flush pulse", {7'd0, fl}, 8'h01);
        check("R4 reset then enable", {7'd0, rx_en}, 8'h01);
        bus_write(6'h08, 8'h20, fl);
        check("R11 reset disables", {7'd0, rx_en}, 8'h00);

        // R12 break
        @(negedge clk); rx_break_evt = 1'b1;
        @(negedge clk); rx_break_evt = 1'b0;
        bus_read(6'h14, rd, pp);
        check("R12 break set", rd, 8'h05);
        bus_write(6'h14, 8'h04, fl);
        check("R12 break irq", {7'd0, irq}, 8'h01);
        bus_write(6'h08, 8'h50, fl);
        bus_read(6'h14, rd, pp);
        check("R12 break cleared", rd, 8'h01);
        check("R12 irq low", {7'd0, irq}, 8'h00);

        // R6 transmitter reset drops pending byte
        bus_write(6'h0C, 8'h11, fl);
        check("R6 pending", {7'd0, tx_valid}, 8'h01);
        bus_write(6'h08, 8'h30, fl);
        check("R6 valid dropped", {7'd0, tx_valid}, 8'h00);
        bus_read(6'h04, rd, pp);
        check("R6 status", rd, 8'h08);

        // R9 reset mid-run
        bus_write(6'h08, 8'h05, fl);
        bus_write(6'h14, 8'hFF, fl);
        do_reset();
        bus_read(6'h04, rd, pp);
        check("R9 status", rd, 8'h08);
        bus_read(6'h14, rd, pp);
        check("R9 isr", rd, 8'h00);
        check("R9 irq", {7'd0, irq}, 8'h00);
        check("R9 rx_en", {7'd0, rx_en}, 8'h00);
        bus_read(6'h00, rd, pp);
        check("R9 mode", rd, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule